// File: doc/BRIEF.md
# Programmable Current-Sink Port Controller

This block holds the control state for an eight-pin port whose pins work as programmable current sinks or as pulled-up inputs. Each pin has a level bit. A level bit of 0 turns the pin's pull-up off and asks the analog cell to sink the current held in that pin's 4-bit strength register. A level bit of 1 turns the sink off and the pull-up on, so the pin floats high and can be read as an input. The analog sinks and resistors sit outside the block. The block only produces the pull-up enable and the 4-bit sink code for each pin.

Every pin can also raise the port's single shared interrupt. The pad levels are synchronized, and an edge on a pin that is armed produces an interrupt pulse if its direction matches that pin's polarity bit. The port-level enable, held in the chip's global interrupt enable register, comes in as an input and gates the request.

Software writes the registers through a simple single-cycle write port. A 2-bit selector chooses the register and a pin index chooses which strength register is written.

Top module: `sinkport_top`

## Requirements
- R1: After reset every level bit is 1, every strength register, arm bit and polarity bit is 0, `pullUpEn` is all ones, `sinkCode` is all zeros and `dacIrq` is 0.
- R2: A write with `regSel`=0 loads `regWdata` into the level bits. For each pin whose level bit is 0, `pullUpEn` for that pin is 0 and the pin's `sinkCode` nibble (bits 4*i+3 down to 4*i) equals its strength register.
- R3: For each pin whose level bit is 1, `pullUpEn` for that pin is 1 and its `sinkCode` nibble is 0, whatever its strength register holds.
- R4: A write with `regSel`=3 loads `regWdata[3:0]` into the strength register of pin `regPin` only. No other pin's strength register changes.
- R5: A write with `regSel`=1 loads the per-pin arm bits. A pin whose arm bit is 0 never causes `dacIrq`.
- R6: A write with `regSel`=2 loads the per-pin polarity bits, where 1 selects a rising edge and 0 a falling edge. A matching edge on an armed pin makes `dacIrq` high for exactly one cycle. This happens after the third rising clock edge following the pad change, and an edge in the other direction causes nothing.
- R7: While `dacGlobalEn` is 0, `dacIrq` stays 0.
- R8: Matching edges on several armed pins in the same cycle produce a single one-cycle `dacIrq` pulse.
- R9: Register writes take effect at the clock edge where `regWe` is 1. While `regWe` is 0, changes on `regSel`, `regPin` and `regWdata` alter no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 level, 1 arm, 2 polarity, 3 strength |
| regPin | input | 3 | Pin index for a strength write |
| regWdata | input | 8 | Write data |
| padIn | input | 8 | Asynchronous pad levels |
| dacGlobalEn | input | 1 | Port-level interrupt enable |
| pullUpEn | output | 8 | Pull-up enable per pin |
| sinkCode | output | 32 | 4-bit sink code per pin, pin i in bits 4*i+3:4*i |
| dacIrq | output | 1 | Shared interrupt request pulse |

## Verification
The assertions assume that the reset is held for at least one clock edge before it is released. They also assume that every input, `padIn` included, is steady around the clock edge once it has been synchronized. The bench drives all inputs on the falling edge only. It holds pad levels for several cycles, so each edge it produces is one clean edge, and it writes registers one at a time. The irq assertions also assume that a cleared arm mask or a low global enable has been in force for a cycle. The stimulus keeps this by settling each configuration before it toggles any pad.

// File: rtl/sinkport_pkg.sv
package sinkport_pkg;
  typedef enum logic [1:0] {
    SEL_LEVEL = 2'd0,
    SEL_ARM   = 2'd1,
    SEL_POL   = 2'd2,
    SEL_SINK  = 2'd3
  } regSel_e;

  // load strobes from control to datapath
  typedef struct packed {
    logic ldLevel;
    logic ldArm;
    logic ldPol;
    logic ldSink;
  } strobe_t;
endpackage

// File: rtl/sinkport_ctrl.sv
module sinkport_ctrl
  import sinkport_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWe,
  input  logic [1:0]      regSel,
  input  logic [PINS-1:0] padIn,
  input  logic [PINS-1:0] armBits,
  input  logic [PINS-1:0] polBits,
  input  logic            globalEn,
  output strobe_t         stb,
  output logic            irq
);
  logic [PINS-1:0] syncA, syncB, lastB;
  logic [PINS-1:0] riseHit, fallHit, pinHit;

  always_comb begin
    stb.ldLevel = regWe && (regSel == SEL_LEVEL);
    stb.ldArm   = regWe && (regSel == SEL_ARM);
    stb.ldPol   = regWe && (regSel == SEL_POL);
    stb.ldSink  = regWe && (regSel == SEL_SINK);
  end

  // two-stage synchronizer plus one history stage; idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '1;
      syncB <= '1;
      lastB <= '1;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      lastB <= syncB;
    end
  end

  assign riseHit = syncB & ~lastB;
  assign fallHit = ~syncB & lastB;
  assign pinHit  = armBits & ((polBits & riseHit) | (~polBits & fallHit));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= globalEn && (|pinHit);
  end
endmodule

// File: rtl/sinkport_dp.sv
module sinkport_dp
  import sinkport_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int CODE_W = 4,
  localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [IDX_W-1:0]       regPin,
  input  logic [PINS-1:0]        regWdata,
  output logic [PINS-1:0]        levelBits,
  output logic [PINS-1:0]        armBits,
  output logic [PINS-1:0]        polBits,
  output logic [PINS*CODE_W-1:0] sinkCode
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelBits <= '1;
      armBits   <= '0;
      polBits   <= '0;
    end else begin
      if (stb.ldLevel) levelBits <= regWdata;
      if (stb.ldArm)   armBits   <= regWdata;
      if (stb.ldPol)   polBits   <= regWdata;
    end
  end

  for (genvar g = 0; g < PINS; g++) begin : gPin
    logic [CODE_W-1:0] strength;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) strength <= '0;
      else if (stb.ldSink && (regPin == IDX_W'(g)))
        strength <= regWdata[CODE_W-1:0];
    end
    // a pulled-up pin never sinks
    assign sinkCode[g*CODE_W +: CODE_W] = levelBits[g] ? '0 : strength;
  end
endmodule

// File: rtl/sinkport_top.sv
module sinkport_top
  import sinkport_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int CODE_W = 4,
  localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWe,
  input  logic [1:0]             regSel,
  input  logic [IDX_W-1:0]       regPin,
  input  logic [PINS-1:0]        regWdata,
  input  logic [PINS-1:0]        padIn,
  input  logic                   dacGlobalEn,
  output logic [PINS-1:0]        pullUpEn,
  output logic [PINS*CODE_W-1:0] sinkCode,
  output logic                   dacIrq
);
  strobe_t         stb;
  logic [PINS-1:0] levelBits, armBits, polBits;

  sinkport_ctrl #(.PINS(PINS)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .padIn(padIn), .armBits(armBits), .polBits(polBits),
    .globalEn(dacGlobalEn), .stb(stb), .irq(dacIrq)
  );

  sinkport_dp #(.PINS(PINS), .CODE_W(CODE_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .regPin(regPin),
    .regWdata(regWdata), .levelBits(levelBits), .armBits(armBits),
    .polBits(polBits), .sinkCode(sinkCode)
  );

  assign pullUpEn = levelBits;
endmodule

// File: rtl/sinkport_chk.sv
module sinkport_chk #(
  parameter int PINS   = 8,
  parameter int CODE_W = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   regWe,
  input logic                   dacGlobalEn,
  input logic [PINS-1:0]        armBits,
  input logic [PINS-1:0]        pullUpEn,
  input logic [PINS*CODE_W-1:0] sinkCode,
  input logic                   dacIrq
);
  for (genvar g = 0; g < PINS; g++) begin : gPinChk
    // R3: a pin with its pull-up on carries a zero sink code
    a_r3_pullup_no_sink: assert property (@(posedge clk) disable iff (!rstN)
      pullUpEn[g] |-> (sinkCode[g*CODE_W +: CODE_W] == '0));
  end

  // R7: port-level enable low blocks the request
  a_r7_global_gate: assert property (@(posedge clk) disable iff (!rstN)
    !dacGlobalEn |=> !dacIrq);

  // R5: with nothing armed no request follows
  a_r5_unarmed_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (armBits == '0) |=> !dacIrq);

  // R9: idle write port leaves the pad controls unchanged
  a_r9_idle_pullup: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> $stable(pullUpEn));

  a_r9_idle_sink: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> $stable(sinkCode));
endmodule

bind sinkport_top sinkport_chk #(.PINS(PINS), .CODE_W(CODE_W)) uChk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .dacGlobalEn(dacGlobalEn),
  .armBits(armBits), .pullUpEn(pullUpEn), .sinkCode(sinkCode),
  .dacIrq(dacIrq)
);

// File: tb/sinkport_top_test.sv
`timescale 1ns/1ps
module sinkport_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [2:0]  regPin = 3'd0;
  logic [7:0]  regWdata = 8'h00;
  logic [7:0]  padIn = 8'hFF;
  logic        dacGlobalEn = 1'b1;
  logic [7:0]  pullUpEn;
  logic [31:0] sinkCode;
  logic        dacIrq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sinkport_top uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regPin(regPin), .regWdata(regWdata), .padIn(padIn),
    .dacGlobalEn(dacGlobalEn), .pullUpEn(pullUpEn),
    .sinkCode(sinkCode), .dacIrq(dacIrq)
  );

  // behavioural reference
  logic [7:0] mLevel, mArm, mPol;
  int         mStrength [8];
  logic       mIrq;
  logic [7:0] padHist [$];

  function automatic logic [31:0] modelCode();
    logic [31:0] c = '0;
    for (int i = 0; i < 8; i++)
      if (!mLevel[i]) c[i*4 +: 4] = 4'(mStrength[i]);
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mLevel = 8'hFF; mArm = 8'h00; mPol = 8'h00; mIrq = 1'b0;
      for (int i = 0; i < 8; i++) mStrength[i] = 0;
      padHist = {8'hFF, 8'hFF, 8'hFF};
    end else begin
      logic [7:0] newer, older;
      bit hit;
      newer = padHist[1];
      older = padHist[0];
      hit = 1'b0;
      for (int i = 0; i < 8; i++) begin
        if (mArm[i] && mPol[i] && newer[i] && !older[i]) hit = 1'b1;
        if (mArm[i] && !mPol[i] && !newer[i] && older[i]) hit = 1'b1;
      end
      mIrq = hit && dacGlobalEn;
      padHist.push_back(padIn);
      void'(padHist.pop_front());
      if (regWe) begin
        case (regSel)
          2'd0: mLevel = regWdata;
          2'd1: mArm = regWdata;
          2'd2: mPol = regWdata;
          default: mStrength[regPin] = int'(regWdata[3:0]);
        endcase
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R2/R3 pullUpEn vs model", 32'(pullUpEn), 32'(mLevel));
      check("R4 sinkCode vs model", sinkCode, modelCode());
      check("R6 dacIrq vs model", 32'(dacIrq), 32'(mIrq));
    end
  end

  task automatic writeReg(logic [1:0] sel, logic [2:0] pin, logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regPin = pin; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // drive pads, then report pulse count and the index of the first pulse
  task automatic padWindow(logic [7:0] p, output int cnt, output int first);
    @(negedge clk);
    padIn = p;
    cnt = 0; first = 0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (dacIrq === 1'b1) begin
        cnt++;
        if (first == 0) first = k;
      end
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt, first;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset pullUpEn", 32'(pullUpEn), 32'hFF);
    check("R1 reset sinkCode", sinkCode, 32'h0);
    check("R1 reset dacIrq", 32'(dacIrq), 32'h0);

    writeReg(2'd3, 3'd3, 8'h09);
    writeReg(2'd3, 3'd0, 8'hAF);
    writeReg(2'd3, 3'd5, 8'h07);
    check("R3 codes hidden while pulled up", sinkCode, 32'h0);

    writeReg(2'd0, 3'd0, 8'hF6);
    check("R2 pullUpEn after level write", 32'(pullUpEn), 32'hF6);
    check("R2 sinkCode pins 0 and 3", sinkCode, 32'h0000_900F);

    writeReg(2'd3, 3'd3, 8'h02);
    check("R4 only pin 3 strength changed", sinkCode, 32'h0000_200F);

    @(negedge clk);
    regSel = 2'd0; regWdata = 8'h00; regPin = 3'd5;
    @(negedge clk);
    regSel = 2'd3; regWdata = 8'h0C;
    @(negedge clk);
    check("R9 idle port pullUpEn", 32'(pullUpEn), 32'hF6);
    check("R9 idle port sinkCode", sinkCode, 32'h0000_200F);

    writeReg(2'd0, 3'd0, 8'hD6);
    check("R3/R2 pin 5 now sinks", sinkCode, 32'h0070_200F);
    writeReg(2'd0, 3'd0, 8'hFF);

    writeReg(2'd1, 3'd0, 8'h12);
    writeReg(2'd2, 3'd0, 8'h02);
    padWindow(8'hFD, cnt, first);
    check("R6 falling on rising-armed pin", 32'(cnt), 32'd0);
    padWindow(8'hFF, cnt, first);
    check("R6 rising pulse count", 32'(cnt), 32'd1);
    check("R6 rising pulse latency", 32'(first), 32'd3);

    padWindow(8'hFB, cnt, first);
    check("R5 unarmed pin 2 falls", 32'(cnt), 32'd0);
    padWindow(8'hFF, cnt, first);
    check("R5 unarmed pin 2 rises", 32'(cnt), 32'd0);

    padWindow(8'hEF, cnt, first);
    check("R6 falling polarity pulse count", 32'(cnt), 32'd1);
    check("R6 falling polarity latency", 32'(first), 32'd3);
    padWindow(8'hFF, cnt, first);
    check("R6 rising on falling-armed pin", 32'(cnt), 32'd0);

    @(negedge clk);
    dacGlobalEn = 1'b0;
    padWindow(8'hFD, cnt, first);
    padWindow(8'hFF, cnt, first);
    check("R7 global enable off", 32'(cnt), 32'd0);
    @(negedge clk);
    dacGlobalEn = 1'b1;

    writeReg(2'd1, 3'd0, 8'h42);
    writeReg(2'd2, 3'd0, 8'h42);
    padWindow(8'hBD, cnt, first);
    padWindow(8'hFF, cnt, first);
    check("R8 simultaneous edges pulse count", 32'(cnt), 32'd1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule